// File: doc/BRIEF.md
# I2C Combined-Format Block Read Engine

This block is the host side of an I2C combined transfer that reads a block of bytes from one target. When started, it puts a start condition on the bus and sends the 7-bit target address with the write direction. It then sends a single command byte and, without releasing the bus, issues a repeated start and the same address with the read direction. It then clocks in a programmed number of data bytes. Every received byte except the last is acknowledged by the host. The last byte gets a not-acknowledge, and a stop condition follows.

The bus is driven as open drain: the block only ever pulls SCL or SDA low, and it reads the resolved SDA level back. SCL timing comes from a divider parameter. Each bit lasts four phases of `DIV` clocks each. Received bytes land in a small buffer that is read through an index port after `done` rises. A configuration that cannot be run is refused on the `go` pulse and the bus is never touched. A target that fails to acknowledge the address or the command ends the transfer with a stop and a device-error flag.

Top module: `i2c_combined_reader`

## Requirements
- R1: After reset, both bus lines are released (`sclDrvLow`=0, `sdaDrvLow`=0) and `busy`, `done`, `cfgErr` and `devErr` are 0. Whenever `busy` is 0, both lines are released.
- R2: An accepted `go` produces a start condition followed by the byte {cfgAddr[7:1], 0}, sent MSB first. A low SDA in the ninth clock counts as the target's acknowledge.
- R3: After the address is acknowledged, the byte in `cfgCmd` is sent MSB first and must also be acknowledged.
- R4: A repeated start then follows, with the byte {cfgAddr[7:1], 1}. A full transfer therefore contains exactly two start conditions and one stop.
- R5: The value of cfgAddr[0] has no effect. The direction bits on the bus are always 0 for the first address and 1 for the second.
- R6: `cfgCount` bytes are received MSB first. Byte k of the transfer (k from 0) is stored at buffer index k, which `rdData` shows when `rdIdx`=k.
- R7: The host drives an acknowledge (SDA low) after each received byte except the last, drives a not-acknowledge after the last, then sends a stop and sets `done`.
- R8: A `cfgCount` of 0, or one above MAX_BYTES (32 by default), sets `cfgErr` and `done` on the `go` pulse. No start is issued and `busy` stays 0.
- R9: If `cfgPecEn` or `cfgAutoAppend` is 1 on the `go` pulse, `cfgErr` and `done` are set and the bus stays idle.
- R10: A not-acknowledge from the target on the write address, the command or the read address sends the engine straight to a stop. It sets `devErr` and `done`, and no further byte is clocked.
- R11: SDA changes only while SCL is held low, except for the SDA edges that form start, repeated start and stop.
- R12: `busy` is 1 from the accepted `go` until the stop completes. `done` is only ever 1 while `busy` is 0, and it clears on the next `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Target address in bits 7:1; bit 0 ignored |
| cfgCmd | input | 8 | Command byte sent before the repeated start |
| cfgCount | input | CNT_W (6) | Number of bytes to read, 1..MAX_BYTES |
| cfgPecEn | input | 1 | Packet-check enable; must be 0 for this transfer |
| cfgAutoAppend | input | 1 | Automatic-append enable; must be 0 for this transfer |
| go | input | 1 | One-cycle start pulse, taken only when idle |
| sdaIn | input | 1 | Resolved SDA level from the bus |
| rdIdx | input | IDX_W (5) | Buffer read index |
| sclDrvLow | output | 1 | 1 pulls SCL low |
| sdaDrvLow | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer or refusal finished |
| cfgErr | output | 1 | Start refused because of configuration |
| devErr | output | 1 | Target failed to acknowledge address or command |
| rdData | output | 8 | Buffer byte at `rdIdx` |

## Verification
Two events share one clock edge at the end of every received byte: the buffer write of the assembled byte, and the decision whether the next ack slot carries an acknowledge or the final not-acknowledge. The index advance happens in the following ack symbol, so the decision has to use the index before it moves. Transfers of one byte and of the full 32 bytes are the tests most likely to expose an index that moves early or late. A bench target model counts the host's acknowledges and not-acknowledges, and the bench compares every buffer entry against the pattern the target sent.

// File: rtl/cmbrd_pkg.sv
package cmbrd_pkg;

  typedef enum logic [1:0] {
    SYM_BIT   = 2'd0,
    SYM_START = 2'd1,
    SYM_STOP  = 2'd2
  } symKind_e;

  typedef enum logic [1:0] {
    TX_SHIFT = 2'd0,
    TX_ZERO  = 2'd1,
    TX_ONE   = 2'd2
  } txSel_e;

  typedef enum logic [2:0] {
    LD_NONE  = 3'd0,
    LD_ADDRW = 3'd1,
    LD_ADDRR = 3'd2,
    LD_CMD   = 3'd3,
    LD_RX    = 3'd4
  } ldSel_e;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic     symGo;
    symKind_e kind;
    txSel_e   txSel;
    logic     latchCfg;
    ldSel_e   ld;
    logic     shift;
    logic     wrBuf;
    logic     incIdx;
  } ctlStrobe_t;

endpackage

// File: rtl/cmbrd_datapath.sv
module cmbrd_datapath
  import cmbrd_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int MAX_BYTES = 32,
  parameter int CNT_W     = 6,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [7:0]       cfgAddr,
  input  logic [7:0]       cfgCmd,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             sdaIn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             symDone,
  output logic             rxBit,
  output logic             lastBit,
  output logic             lastByte,
  output logic [7:0]       rdData
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       quarter;
  logic             symActive;
  symKind_e         kindQ;
  logic             txLowQ;
  logic             divEnd;
  logic             sclNext, sdaNext;
  logic [7:0]       addrQ, cmdQ, shiftQ;
  logic [CNT_W-1:0] cntQ, idxQ;
  logic [2:0]       bitCnt;
  logic             rxQ;
  logic [7:0]       mem [MAX_BYTES];

  assign divEnd   = (divCnt == DIV_W'(DIV - 1));
  assign symDone  = symActive && (quarter == 2'd3) && divEnd;
  assign rxBit    = rxQ;
  assign lastBit  = (bitCnt == 3'd7);
  assign lastByte = (idxQ == cntQ - CNT_W'(1));
  assign rdData   = mem[rdIdx];

  // Line levels per symbol phase; phase 0 keeps SDA as it was
  always_comb begin
    sclNext = 1'b1;
    sdaNext = sdaDrvLow;
    case (kindQ)
      SYM_BIT: begin
        sclNext = (quarter < 2'd2);
        if (quarter != 2'd0) sdaNext = txLowQ;
      end
      SYM_START: begin
        sclNext = (quarter < 2'd2);
        if (quarter == 2'd1 || quarter == 2'd2) sdaNext = 1'b0;
        if (quarter == 2'd3) sdaNext = 1'b1;
      end
      SYM_STOP: begin
        sclNext = (quarter < 2'd2);
        if (quarter == 2'd1 || quarter == 2'd2) sdaNext = 1'b1;
        if (quarter == 2'd3) sdaNext = 1'b0;
      end
      default: begin
        sclNext = 1'b0;
        sdaNext = 1'b0;
      end
    endcase
  end

  // Symbol timing engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      quarter   <= '0;
      symActive <= 1'b0;
      kindQ     <= SYM_BIT;
      txLowQ    <= 1'b0;
      rxQ       <= 1'b1;
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else begin
      if (ctl.symGo) begin
        symActive <= 1'b1;
        quarter   <= 2'd0;
        divCnt    <= '0;
        kindQ     <= ctl.kind;
        case (ctl.txSel)
          TX_SHIFT: txLowQ <= ~shiftQ[7];
          TX_ZERO:  txLowQ <= 1'b1;
          default:  txLowQ <= 1'b0;
        endcase
      end else if (symActive) begin
        if (divEnd) begin
          divCnt  <= '0;
          quarter <= quarter + 2'd1;
          if (quarter == 2'd3) symActive <= 1'b0;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
      if (symActive && quarter == 2'd2 && divEnd) rxQ <= sdaIn;
      if (symActive) begin
        sclDrvLow <= sclNext;
        sdaDrvLow <= sdaNext;
      end
    end
  end

  // Byte shifter, bit count, buffer index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      cmdQ   <= '0;
      cntQ   <= '0;
      idxQ   <= '0;
      shiftQ <= '0;
      bitCnt <= '0;
    end else begin
      if (ctl.latchCfg) begin
        addrQ <= cfgAddr;
        cmdQ  <= cfgCmd;
        cntQ  <= cfgCount;
        idxQ  <= '0;
      end
      case (ctl.ld)
        LD_ADDRW: begin shiftQ <= addrQ & 8'hFE; bitCnt <= '0; end
        LD_ADDRR: begin shiftQ <= addrQ | 8'h01; bitCnt <= '0; end
        LD_CMD:   begin shiftQ <= cmdQ;          bitCnt <= '0; end
        LD_RX:    begin shiftQ <= '0;            bitCnt <= '0; end
        default: begin
          if (ctl.shift) begin
            shiftQ <= {shiftQ[6:0], rxQ};
            bitCnt <= bitCnt + 3'd1;
          end
        end
      endcase
      if (ctl.incIdx) idxQ <= idxQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrBuf) mem[idxQ[IDX_W-1:0]] <= {shiftQ[6:0], rxQ};
  end

  // R11: data line moves only under a low clock outside start/stop symbols
  a_r11_sda_under_low_scl: assert property (@(posedge clk) disable iff (!rstN)
    (($past(sdaDrvLow) != sdaDrvLow) && kindQ == SYM_BIT) |-> (sclDrvLow && $past(sclDrvLow)));

  // R6: the write index never passes the programmed count
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= cntQ);

endmodule

// File: rtl/cmbrd_control.sv
module cmbrd_control
  import cmbrd_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic             cfgPecEn,
  input  logic             cfgAutoAppend,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             symDone,
  input  logic             rxBit,
  input  logic             lastBit,
  input  logic             lastByte,
  output ctlStrobe_t       ctl,
  output logic             busy,
  output logic             done,
  output logic             cfgErr,
  output logic             devErr
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDRW, ST_ACKW, ST_CMD, ST_ACKC,
    ST_RSTART, ST_ADDRR, ST_ACKR, ST_RDBIT, ST_HACK, ST_STOP
  } state_e;

  state_e state;
  logic   launch;
  logic   badCfg;

  assign badCfg = cfgPecEn || cfgAutoAppend || (cfgCount == '0) ||
                  (cfgCount > CNT_W'(MAX_BYTES));
  assign busy   = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    ctl.kind  = SYM_BIT;
    ctl.txSel = TX_ONE;
    ctl.ld    = LD_NONE;
    ctl.symGo = launch && busy;
    case (state)
      ST_IDLE:   ctl.latchCfg = go && !badCfg;
      ST_START, ST_RSTART: begin
        ctl.kind = SYM_START;
        if (symDone) ctl.ld = (state == ST_START) ? LD_ADDRW : LD_ADDRR;
      end
      ST_ADDRW, ST_CMD, ST_ADDRR: begin
        ctl.txSel = TX_SHIFT;
        ctl.shift = symDone;
      end
      ST_ACKW: if (symDone && !rxBit) ctl.ld = LD_CMD;
      ST_ACKR: if (symDone && !rxBit) ctl.ld = LD_RX;
      ST_RDBIT: begin
        ctl.shift = symDone;
        ctl.wrBuf = symDone && lastBit;
      end
      ST_HACK: begin
        ctl.txSel  = lastByte ? TX_ONE : TX_ZERO;
        ctl.incIdx = symDone;
      end
      ST_STOP:   ctl.kind = SYM_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      launch <= 1'b0;
      done   <= 1'b0;
      cfgErr <= 1'b0;
      devErr <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (go) begin
        devErr <= 1'b0;
        if (badCfg) begin
          cfgErr <= 1'b1;
          done   <= 1'b1;
        end else begin
          cfgErr <= 1'b0;
          done   <= 1'b0;
          state  <= ST_START;
          launch <= 1'b1;
        end
      end
    end else begin
      if (ctl.symGo) launch <= 1'b0;
      if (symDone) begin
        launch <= 1'b1;
        case (state)
          ST_START:  state <= ST_ADDRW;
          ST_ADDRW:  if (lastBit) state <= ST_ACKW;
          ST_ACKW:   if (rxBit) begin state <= ST_STOP; devErr <= 1'b1; end
                     else state <= ST_CMD;
          ST_CMD:    if (lastBit) state <= ST_ACKC;
          ST_ACKC:   if (rxBit) begin state <= ST_STOP; devErr <= 1'b1; end
                     else state <= ST_RSTART;
          ST_RSTART: state <= ST_ADDRR;
          ST_ADDRR:  if (lastBit) state <= ST_ACKR;
          ST_ACKR:   if (rxBit) begin state <= ST_STOP; devErr <= 1'b1; end
                     else state <= ST_RDBIT;
          ST_RDBIT:  if (lastBit) state <= ST_HACK;
          ST_HACK:   state <= lastByte ? ST_STOP : ST_RDBIT;
          ST_STOP: begin
            state  <= ST_IDLE;
            launch <= 1'b0;
            done   <= 1'b1;
          end
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8/R9: a refused start leaves the engine idle with the error flag up
  a_r8_refuse_bad_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && go && badCfg) |=> (state == ST_IDLE && cfgErr && done));

  // R10: a missing target acknowledge leads straight to the stop symbol
  a_r10_nak_to_stop: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACKW || state == ST_ACKC || state == ST_ACKR) && symDone && rxBit)
      |=> (state == ST_STOP && devErr));

  // R12: completion is only reported when the engine is idle
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == ST_IDLE));

endmodule

// File: rtl/i2c_combined_reader.sv
module i2c_combined_reader
  import cmbrd_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int MAX_BYTES = 32,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cfgAddr,
  input  logic [7:0]       cfgCmd,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgPecEn,
  input  logic             cfgAutoAppend,
  input  logic             go,
  input  logic             sdaIn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             busy,
  output logic             done,
  output logic             cfgErr,
  output logic             devErr,
  output logic [7:0]       rdData
);

  ctlStrobe_t ctl;
  logic       symDone, rxBit, lastBit, lastByte;

  cmbrd_control #(
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .go           (go),
    .cfgPecEn     (cfgPecEn),
    .cfgAutoAppend(cfgAutoAppend),
    .cfgCount     (cfgCount),
    .symDone      (symDone),
    .rxBit        (rxBit),
    .lastBit      (lastBit),
    .lastByte     (lastByte),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done),
    .cfgErr       (cfgErr),
    .devErr       (devErr)
  );

  cmbrd_datapath #(
    .DIV      (DIV),
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cfgAddr  (cfgAddr),
    .cfgCmd   (cfgCmd),
    .cfgCount (cfgCount),
    .sdaIn    (sdaIn),
    .rdIdx    (rdIdx),
    .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow),
    .symDone  (symDone),
    .rxBit    (rxBit),
    .lastBit  (lastBit),
    .lastByte (lastByte),
    .rdData   (rdData)
  );

  // R1: an idle engine leaves both lines released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDrvLow && !sdaDrvLow));

endmodule

// File: tb/i2c_combined_reader_bench.sv
`timescale 1ns/1ps
module i2c_combined_reader_bench;

  localparam int DIV = 2;
  localparam int MAXB = 32;
  localparam logic [6:0] TGT = 7'h50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgAddr = '0, cfgCmd = '0;
  logic [5:0] cfgCount = '0;
  logic       cfgPecEn = 1'b0, cfgAutoAppend = 1'b0, go = 1'b0;
  logic [4:0] rdIdx = '0;
  logic       sclDrvLow, sdaDrvLow, busy, done, cfgErr, devErr;
  logic [7:0] rdData;
  logic       sdaIn;

  int nTests = 0, nFail = 0, cycles = 0;

  // target model state
  logic tgtLow = 1'b0;
  logic ackW = 1'b1, ackC = 1'b1, ackR = 1'b1;
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic [7:0] inByte, txByte, cmdSeen;
  logic [7:0] addrLog [4];
  logic acked, lastNak;
  int mode = 0, bitCnt = 0, addrN = 0, cmdN = 0, starts = 0, stops = 0;
  int sent = 0, hostAcks = 0, hostNaks = 0, seed = 0;
  logic busyEarly;

  assign sdaIn = !(sdaDrvLow || tgtLow);

  always #5 clk = ~clk;

  i2c_combined_reader #(.DIV(DIV), .MAX_BYTES(MAXB)) u_i2c_combined_reader (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgCmd(cfgCmd), .cfgCount(cfgCount),
    .cfgPecEn(cfgPecEn), .cfgAutoAppend(cfgAutoAppend), .go(go), .sdaIn(sdaIn),
    .rdIdx(rdIdx), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .busy(busy),
    .done(done), .cfgErr(cfgErr), .devErr(devErr), .rdData(rdData));

  function automatic logic [7:0] dataAt(int k);
    return 8'((k * 37 + seed * 11) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural target, evaluated mid-cycle
  always @(negedge clk) begin
    logic sclB, sdaB;
    cycles++;
    sclB = !sclDrvLow;
    sdaB = !(sdaDrvLow || tgtLow);
    if (sclB && prevScl && prevSda && !sdaB) begin
      starts++; mode = 1; bitCnt = 0;
    end else if (sclB && prevScl && !prevSda && sdaB) begin
      stops++; mode = 0; tgtLow = 1'b0;
    end else if (sclB && !prevScl) begin
      if (mode == 1 || mode == 2) begin
        if (bitCnt < 8) inByte = {inByte[6:0], sdaB};
        bitCnt++;
      end else if (mode == 3) begin
        if (bitCnt == 8) begin
          lastNak = sdaB;
          if (sdaB) hostNaks++; else hostAcks++;
        end
        bitCnt++;
      end
    end else if (!sclB && prevScl) begin
      if (mode == 1 || mode == 2) begin
        if (bitCnt == 8) begin
          if (mode == 1) begin
            if (addrN < 4) addrLog[addrN] = inByte;
            addrN++;
            tgtLow = (inByte[7:1] == TGT) && (inByte[0] ? ackR : ackW);
          end else begin
            cmdSeen = inByte; cmdN++;
            tgtLow = ackC;
          end
          acked = tgtLow;
        end else if (bitCnt == 9) begin
          tgtLow = 1'b0; bitCnt = 0;
          if (!acked) mode = 0;
          else if (mode == 1 && inByte[0]) begin
            mode = 3; txByte = dataAt(sent); tgtLow = !txByte[7];
          end else if (mode == 1) mode = 2;
          else mode = 0;
        end
      end else if (mode == 3) begin
        if (bitCnt >= 1 && bitCnt <= 7) tgtLow = !txByte[7 - bitCnt];
        else if (bitCnt == 8) tgtLow = 1'b0;
        else if (bitCnt == 9) begin
          sent++; bitCnt = 0;
          if (lastNak) begin mode = 0; tgtLow = 1'b0; end
          else begin txByte = dataAt(sent); tgtLow = !txByte[7]; end
        end
      end
    end
    prevScl = sclB;
    prevSda = !(sdaDrvLow || tgtLow);
  end

  task automatic clearTarget(input int s);
    seed = s; addrN = 0; cmdN = 0; starts = 0; stops = 0;
    sent = 0; hostAcks = 0; hostNaks = 0; cmdSeen = '0;
    ackW = 1'b1; ackC = 1'b1; ackR = 1'b1;
    for (int i = 0; i < 4; i++) addrLog[i] = '0;
  endtask

  task automatic runTxn(input logic [7:0] a, input logic [7:0] c, input int n,
                        input logic pec, input logic app);
    int w;
    @(negedge clk);
    cfgAddr = a; cfgCmd = c; cfgCount = 6'(n); cfgPecEn = pec; cfgAutoAppend = app;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    busyEarly = busy;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) chk("R12 transfer timeout", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkBuffer(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      rdIdx = 5'(i);
      #1;
      chk(tag, rdData, dataAt(i));
    end
  endtask

  task automatic t_reset;
    chk("R1 scl released", sclDrvLow, 0);
    chk("R1 sda released", sdaDrvLow, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 errors", {cfgErr, devErr}, 0);
  endtask

  task automatic t_basic;
    clearTarget(1);
    runTxn(8'hA0, 8'h5A, 3, 1'b0, 1'b0);
    chk("R12 busy during transfer", busyEarly, 1);
    chk("R2 write address byte", addrLog[0], 8'hA0);
    chk("R3 command byte", cmdSeen, 8'h5A);
    chk("R4 read address byte", addrLog[1], 8'hA1);
    chk("R4 start count", starts, 2);
    chk("R11 stop count", stops, 1);
    checkBuffer("R6 buffer byte", 3);
    chk("R7 host acks", hostAcks, 2);
    chk("R7 host naks", hostNaks, 1);
    chk("R7 done flags", {done, busy, cfgErr, devErr}, 4'b1000);
    chk("R1 lines idle after stop", {sclDrvLow, sdaDrvLow}, 0);
  endtask

  task automatic t_lsb_ignored;
    clearTarget(2);
    runTxn(8'hA1, 8'hC3, 2, 1'b0, 1'b0);
    chk("R5 first direction bit", addrLog[0], 8'hA0);
    chk("R5 second direction bit", addrLog[1], 8'hA1);
    checkBuffer("R5 data intact", 2);
  endtask

  task automatic t_single;
    clearTarget(3);
    runTxn(8'hA0, 8'h01, 1, 1'b0, 1'b0);
    chk("R7 single byte acks", hostAcks, 0);
    chk("R7 single byte nak", hostNaks, 1);
    checkBuffer("R6 single byte", 1);
  endtask

  task automatic t_max;
    clearTarget(4);
    runTxn(8'hA0, 8'hFF, 32, 1'b0, 1'b0);
    chk("R6 bytes sent", sent, 32);
    chk("R7 max acks", hostAcks, 31);
    chk("R7 max naks", hostNaks, 1);
    checkBuffer("R6 max buffer", 32);
  endtask

  task automatic t_bad_count;
    clearTarget(5);
    runTxn(8'hA0, 8'h11, 0, 1'b0, 1'b0);
    chk("R8 zero count flags", {done, cfgErr, busyEarly}, 3'b110);
    chk("R8 zero count no start", starts, 0);
    clearTarget(5);
    runTxn(8'hA0, 8'h11, 33, 1'b0, 1'b0);
    chk("R8 over count flags", {done, cfgErr, busyEarly}, 3'b110);
    chk("R8 over count no start", starts, 0);
  endtask

  task automatic t_mode_bits;
    clearTarget(6);
    runTxn(8'hA0, 8'h22, 4, 1'b1, 1'b0);
    chk("R9 packet check refused", {cfgErr, starts[0], busyEarly}, 3'b100);
    clearTarget(6);
    runTxn(8'hA0, 8'h22, 4, 1'b0, 1'b1);
    chk("R9 append refused", {cfgErr, starts[0], busyEarly}, 3'b100);
    chk("R9 bus untouched", addrN, 0);
  endtask

  task automatic t_addr_nak;
    clearTarget(7);
    ackW = 1'b0;
    runTxn(8'hA0, 8'h33, 4, 1'b0, 1'b0);
    chk("R10 addr nak flags", {done, devErr, cfgErr}, 3'b110);
    chk("R10 addr nak no command", cmdN, 0);
    chk("R10 addr nak stop", {starts[3:0], stops[3:0]}, 8'h11);
  endtask

  task automatic t_cmd_nak;
    clearTarget(8);
    ackC = 1'b0;
    runTxn(8'hA0, 8'h44, 4, 1'b0, 1'b0);
    chk("R10 cmd nak flag", devErr, 1);
    chk("R10 cmd nak no restart", starts, 1);
    chk("R10 cmd nak stop", stops, 1);
  endtask

  task automatic t_rd_nak;
    clearTarget(9);
    ackR = 1'b0;
    runTxn(8'hA0, 8'h55, 4, 1'b0, 1'b0);
    chk("R10 read addr nak flag", devErr, 1);
    chk("R10 read addr nak no data", sent, 0);
    chk("R10 read addr nak bus", {starts[3:0], stops[3:0]}, 8'h21);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_lsb_ignored;
    t_single;
    t_max;
    t_bad_count;
    t_mode_bits;
    t_addr_nak;
    t_cmd_nak;
    t_rd_nak;
    t_basic;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule